// File: doc/BRIEF.md
# Interrupt entry and return sequencer

This block sits beside a 16-bit CPU core and runs the state-saving work around an interrupt. When the core signals that an instruction has finished, the block looks at every pending cause. If one of them wins, it pushes FLAGS, CS and IP onto the stack. It clears the interrupt-enable and trap flags. It then fetches the handler's IP and CS from a vector table that sits at physical address zero. When the finished instruction is a return-from-interrupt, the block instead pops IP, CS and FLAGS in that order.

The core owns the architectural registers. It shows their current values to the block. The block sends back one write strobe and one value per register, and the core commits each write at the next clock edge. All stack and table traffic goes over a single word-wide memory port with a valid/ready handshake. A request is held unchanged until `mem_ready` is seen high. Read data is taken in the handshake cycle. A slow memory only stretches the sequence and does not change it. For INT 3, the core presents type 3 on the software type input.

Top module: `trap_entry_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `busy`, `mem_valid` and every register write strobe are low.
- R2: Causes are evaluated only in a cycle where `insn_end` is high and the block is idle. With `insn_end` low, no cause starts any activity.
- R3: An entry performs three stack writes: FLAGS at SS:SP-2, CS at SS:SP-4 and IP at SS:SP-6. The physical address is SS×16+offset. SP is written with the pre-decremented value on each push and ends at SP-6.
- R4: In the handshake cycle of the FLAGS push, FLAGS is written back with bit 9 (interrupt enable) and bit 8 (trap) cleared. All other bits are kept.
- R5: After the pushes, IP is loaded from physical word address type×4 and then CS from type×4+2. Both reads use segment 0, so every vector read lies below 400h.
- R6: When several causes are present, the winner is taken in this order, highest first: divide fault (type 0), software interrupt (its 8-bit operand type, 0..255), overflow trap (type 4), NMI (type 2), external request (its 8-bit type), single step (type 1).
- R7: The overflow trap enters only if FLAGS bit 11 is set. Otherwise it causes no memory traffic and no register write.
- R8: NMI is recognised on a rising edge of `nmi_pin`. The edge stays pending until an NMI entry is taken. A pin that is held high gives only one entry.
- R9: The external request is level-sensitive and is ignored while FLAGS bit 9 is clear.
- R10: If FLAGS bit 8 is set at a boundary where nothing of higher priority is present, a type 1 entry is taken.
- R11: When `iret_end` and `insn_end` are both high, the return sequence runs. It pops IP from SS:SP, CS from SS:SP+2 and FLAGS from SS:SP+4. FLAGS is restored unmodified and SP ends at SP+6. This has priority over any entry at that boundary.
- R12: `busy` rises in the cycle after the accepted boundary. It stays high until the final load (CS on entry, FLAGS on return) has completed. Boundaries signalled while busy are ignored.
- R13: While `mem_valid` is high and `mem_ready` is low, the address, write enable and write data hold steady. A step advances only on a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_end | input | 1 | The current instruction has completed this cycle |
| iret_end | input | 1 | The completing instruction is a return-from-interrupt |
| div_fault | input | 1 | The completing instruction raised a divide fault |
| swi_req | input | 1 | The completing instruction is a software interrupt |
| swi_type | input | 8 | Type operand of the software interrupt |
| ovf_req | input | 1 | The completing instruction is an overflow trap check |
| nmi_pin | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_req | input | 1 | External maskable request, level-sensitive |
| intr_type | input | 8 | Type supplied with the external request |
| cs_cur | input | 16 | Current code segment |
| ip_cur | input | 16 | Current instruction pointer |
| ss_cur | input | 16 | Current stack segment |
| sp_cur | input | 16 | Current stack pointer |
| flags_cur | input | 16 | Current flags word |
| cs_we | output | 1 | CS write strobe |
| cs_wdata | output | 16 | New CS value |
| ip_we | output | 1 | IP write strobe |
| ip_wdata | output | 16 | New IP value |
| sp_we | output | 1 | SP write strobe |
| sp_wdata | output | 16 | New SP value |
| flags_we | output | 1 | FLAGS write strobe |
| flags_wdata | output | 16 | New FLAGS value |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or answers the request |
| mem_we | output | 1 | High for a write request, low for a read |
| mem_addr | output | 20 | Physical byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the handshake cycle |
| busy | output | 1 | Entry or return sequence in progress |

## Verification
The accepted boundary is the clock edge where `insn_end` is sampled. The first memory request appears in the cycle after that edge. With `mem_ready` high throughout, each memory step takes one cycle: an entry finishes after five steps and a return after three. `busy` falls one cycle after the final handshake. Each register strobe is high in its own handshake cycle, and the register model commits it at the next edge. The bench therefore waits at falling edges until `busy` is low before it compares registers and the write log, so the checks do not depend on how long the memory stalls. Cases where no entry is expected are observed for three further cycles, to confirm that no request or write appears.

// File: rtl/tes_pkg.sv
package tes_pkg;
  // flag bit positions the sequence depends on
  localparam int unsigned FLAG_TF = 8;
  localparam int unsigned FLAG_IF = 9;
  localparam int unsigned FLAG_OF = 11;

  // priority levels, index 0 is the highest
  typedef enum logic [2:0] {
    SRC_DIV  = 3'd0,
    SRC_SWI  = 3'd1,
    SRC_OVF  = 3'd2,
    SRC_NMI  = 3'd3,
    SRC_INTR = 3'd4,
    SRC_STEP = 3'd5
  } src_e;
  localparam int unsigned N_SRC = 6;

  typedef enum logic [3:0] {
    S_IDLE, S_PSH_FL, S_PSH_CS, S_PSH_IP, S_VEC_IP, S_VEC_CS,
    S_POP_IP, S_POP_CS, S_POP_FL
  } step_e;
endpackage

// File: rtl/tes_pick.sv
module tes_pick
  import tes_pkg::*;
#(
  parameter int TYPE_W = 8
) (
  input  logic              div_fault,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              ovf_req,
  input  logic              of_flag,
  input  logic              nmi_pend,
  input  logic              intr_req,
  input  logic              if_flag,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic              tf_flag,
  output logic              take,
  output logic              take_nmi,
  output logic [TYPE_W-1:0] win_type
);
  logic [N_SRC-1:0] lvl;
  logic [TYPE_W-1:0] lvl_type [N_SRC];

  always_comb begin
    lvl[SRC_DIV]       = div_fault;
    lvl[SRC_SWI]       = swi_req;
    lvl[SRC_OVF]       = ovf_req & of_flag;
    lvl[SRC_NMI]       = nmi_pend;
    lvl[SRC_INTR]      = intr_req & if_flag;
    lvl[SRC_STEP]      = tf_flag;
    lvl_type[SRC_DIV]  = TYPE_W'(0);
    lvl_type[SRC_SWI]  = swi_type;
    lvl_type[SRC_OVF]  = TYPE_W'(4);
    lvl_type[SRC_NMI]  = TYPE_W'(2);
    lvl_type[SRC_INTR] = intr_type;
    lvl_type[SRC_STEP] = TYPE_W'(1);
  end

  // scan from lowest priority up so the highest active level is kept last
  always_comb begin
    take     = |lvl;
    win_type = '0;
    take_nmi = 1'b0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (lvl[i]) begin
        win_type = lvl_type[i];
        take_nmi = (i == int'(SRC_NMI));
      end
    end
  end
endmodule

// File: rtl/tes_edge.sv
module tes_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clear,
  output logic pend
);
  logic prev_q, pend_q;

  // a fresh edge is visible in the same cycle it arrives
  assign pend = pend_q | (pin & ~prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin;
      pend_q <= pend & ~clear;
    end
  end
endmodule

// File: rtl/tes_agen.sv
module tes_agen #(
  parameter int DW     = 16,
  parameter int ADDR_W = 20
) (
  input  logic [DW-1:0]     seg,
  input  logic [DW-1:0]     off,
  output logic [ADDR_W-1:0] phys
);
  localparam int SHIFT = ADDR_W - DW;

  assign phys = (ADDR_W'(seg) << SHIFT) + ADDR_W'(off);
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import tes_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_end,
  input  logic              iret_end,
  input  logic              div_fault,
  input  logic              swi_req,
  input  logic [TYPE_W-1:0] swi_type,
  input  logic              ovf_req,
  input  logic              nmi_pin,
  input  logic              intr_req,
  input  logic [TYPE_W-1:0] intr_type,
  input  logic [DW-1:0]     cs_cur,
  input  logic [DW-1:0]     ip_cur,
  input  logic [DW-1:0]     ss_cur,
  input  logic [DW-1:0]     sp_cur,
  input  logic [DW-1:0]     flags_cur,
  output logic              cs_we,
  output logic [DW-1:0]     cs_wdata,
  output logic              ip_we,
  output logic [DW-1:0]     ip_wdata,
  output logic              sp_we,
  output logic [DW-1:0]     sp_wdata,
  output logic              flags_we,
  output logic [DW-1:0]     flags_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy
);
  localparam logic [DW-1:0] CLR_MASK = (DW'(1) << FLAG_IF) | (DW'(1) << FLAG_TF);
  localparam logic [DW-1:0] WSTEP    = DW'(2);
  localparam int            PAD      = DW - TYPE_W - 2;

  step_e             st_q, st_d;
  logic [DW-1:0]     cs_w, ip_w, ss_w, sp_w, fl_w;
  logic [TYPE_W-1:0] ty_w;

  logic              take, take_nmi, nmi_pend, nmi_clr, start, hs;
  logic [TYPE_W-1:0] win_type;
  logic              is_push, is_pop, is_vec;
  logic [DW-1:0]     seg, off;

  tes_edge i_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .pin   (nmi_pin),
    .clear (nmi_clr),
    .pend  (nmi_pend)
  );

  tes_pick #(.TYPE_W(TYPE_W)) i_pick (
    .div_fault (div_fault),
    .swi_req   (swi_req),
    .swi_type  (swi_type),
    .ovf_req   (ovf_req),
    .of_flag   (flags_cur[FLAG_OF]),
    .nmi_pend  (nmi_pend),
    .intr_req  (intr_req),
    .if_flag   (flags_cur[FLAG_IF]),
    .intr_type (intr_type),
    .tf_flag   (flags_cur[FLAG_TF]),
    .take      (take),
    .take_nmi  (take_nmi),
    .win_type  (win_type)
  );

  tes_agen #(.DW(DW), .ADDR_W(ADDR_W)) i_agen (
    .seg  (seg),
    .off  (off),
    .phys (mem_addr)
  );

  assign start   = (st_q == S_IDLE) & insn_end;
  assign nmi_clr = start & ~iret_end & take_nmi;
  assign busy    = (st_q != S_IDLE);
  assign hs      = mem_valid & mem_ready;

  // memory request for the current step
  always_comb begin
    is_push   = (st_q == S_PSH_FL) || (st_q == S_PSH_CS) || (st_q == S_PSH_IP);
    is_pop    = (st_q == S_POP_IP) || (st_q == S_POP_CS) || (st_q == S_POP_FL);
    is_vec    = (st_q == S_VEC_IP) || (st_q == S_VEC_CS);
    mem_valid = busy;
    mem_we    = is_push;
    seg       = is_vec ? '0 : ss_w;
    if (is_push)     off = sp_w - WSTEP;
    else if (is_pop) off = sp_w;
    else             off = {{PAD{1'b0}}, ty_w, (st_q == S_VEC_CS), 1'b0};
    case (st_q)
      S_PSH_FL: mem_wdata = fl_w;
      S_PSH_CS: mem_wdata = cs_w;
      S_PSH_IP: mem_wdata = ip_w;
      default:  mem_wdata = '0;
    endcase
  end

  // register write strobes, each in its handshake cycle
  always_comb begin
    sp_we       = hs & (is_push | is_pop);
    sp_wdata    = is_push ? sp_w - WSTEP : sp_w + WSTEP;
    flags_we    = hs & ((st_q == S_PSH_FL) | (st_q == S_POP_FL));
    flags_wdata = (st_q == S_PSH_FL) ? (fl_w & ~CLR_MASK) : mem_rdata;
    ip_we       = hs & ((st_q == S_VEC_IP) | (st_q == S_POP_IP));
    ip_wdata    = mem_rdata;
    cs_we       = hs & ((st_q == S_VEC_CS) | (st_q == S_POP_CS));
    cs_wdata    = mem_rdata;
  end

  always_comb begin
    case (st_q)
      S_PSH_FL: st_d = S_PSH_CS;
      S_PSH_CS: st_d = S_PSH_IP;
      S_PSH_IP: st_d = S_VEC_IP;
      S_VEC_IP: st_d = S_VEC_CS;
      S_POP_IP: st_d = S_POP_CS;
      S_POP_CS: st_d = S_POP_FL;
      default:  st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cs_w <= '0;
      ip_w <= '0;
      ss_w <= '0;
      sp_w <= '0;
      fl_w <= '0;
      ty_w <= '0;
    end else if (start) begin
      if (iret_end) begin
        st_q <= S_POP_IP;
        ss_w <= ss_cur;
        sp_w <= sp_cur;
      end else if (take) begin
        st_q <= S_PSH_FL;
        cs_w <= cs_cur;
        ip_w <= ip_cur;
        ss_w <= ss_cur;
        sp_w <= sp_cur;
        fl_w <= flags_cur;
        ty_w <= win_type;
      end
    end else if (hs) begin
      st_q <= st_d;
      if (is_push)     sp_w <= sp_w - WSTEP;
      else if (is_pop) sp_w <= sp_w + WSTEP;
    end
  end
endmodule

// File: rtl/tes_chk.sv
module tes_chk
  import tes_pkg::*;
#(
  parameter int DW     = 16,
  parameter int ADDR_W = 20,
  parameter int TYPE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_end,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              flags_we,
  input logic [DW-1:0]     flags_wdata,
  input logic              ip_we,
  input logic              cs_we,
  input logic              sp_we
);
  // R2: nothing starts without an instruction boundary
  a_r2_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !insn_end) |=> !busy);

  // R4: the flag write during the push clears interrupt enable and trap
  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_we && mem_we) |-> (!flags_wdata[FLAG_IF] && !flags_wdata[FLAG_TF]));

  // R5: IP loads that do not move SP come from the vector table
  a_r5_vector_region: assert property (@(posedge clk) disable iff (!rst_n)
    (ip_we && !sp_we) |-> ((mem_addr >> (TYPE_W + 2)) == '0));

  // R12: busy ends only right after the final CS or FLAGS load
  a_r12_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(cs_we) || $past(flags_we)));

  // R13: a stalled request is held unchanged
  a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));
endmodule

bind trap_entry_seq tes_chk #(.DW(DW), .ADDR_W(ADDR_W), .TYPE_W(TYPE_W)) i_chk (.*);

// File: tb/test_trap_entry_seq.sv
module test_trap_entry_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;

  logic        rst_n = 1'b0, insn_end = 1'b0, iret_end = 1'b0, div_fault = 1'b0;
  logic        swi_req = 1'b0, ovf_req = 1'b0, nmi_pin = 1'b0, intr_req = 1'b0;
  logic [7:0]  swi_type = '0, intr_type = '0;
  logic [15:0] cs_cur = '0, ip_cur = '0, ss_cur = '0, sp_cur = '0, flags_cur = '0;
  logic        cs_we, ip_we, sp_we, flags_we, mem_valid, mem_ready, mem_we, busy;
  logic [15:0] cs_wdata, ip_wdata, sp_wdata, flags_wdata, mem_wdata, mem_rdata;
  logic [19:0] mem_addr;

  trap_entry_seq i_trap_entry_seq (.*);

  // core register model
  logic        set_req = 1'b0;
  logic [15:0] set_cs = '0, set_ip = '0, set_sp = '0, set_fl = '0;
  always @(posedge clk) begin
    if (set_req) begin
      cs_cur <= set_cs; ip_cur <= set_ip; ss_cur <= 16'h2000;
      sp_cur <= set_sp; flags_cur <= set_fl;
    end else begin
      if (cs_we)    cs_cur    <= cs_wdata;
      if (ip_we)    ip_cur    <= ip_wdata;
      if (sp_we)    sp_cur    <= sp_wdata;
      if (flags_we) flags_cur <= flags_wdata;
    end
  end

  // memory model: write log, reads hit the log or a fixed pattern
  logic        clr_log = 1'b0;
  logic [19:0] lg_a [32];
  logic [15:0] lg_d [32];
  int          wn = 0;
  always @(posedge clk) begin
    if (clr_log) wn <= 0;
    else if (mem_valid && mem_ready && mem_we && wn < 32) begin
      lg_a[wn] <= mem_addr;
      lg_d[wn] <= mem_wdata;
      wn <= wn + 1;
    end
  end
  always_comb begin
    mem_rdata = mem_addr[15:0] ^ 16'h5A3C;
    for (int k = 0; k < 32; k++)
      if (k < wn && lg_a[k] == mem_addr) mem_rdata = lg_d[k];
  end

  logic       stall_en = 1'b0;
  logic [1:0] rc = '0;
  always @(negedge clk) rc <= rc + 2'd1;
  assign mem_ready = !stall_en || (rc == 2'd3);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] vecw(input int a);
    return 16'(a) ^ 16'h5A3C;
  endfunction

  task automatic set_regs(input logic [15:0] c, input logic [15:0] i,
                          input logic [15:0] s, input logic [15:0] f);
    @(negedge clk);
    set_cs = c; set_ip = i; set_sp = s; set_fl = f;
    set_req = 1'b1; clr_log = 1'b1;
    @(negedge clk);
    set_req = 1'b0; clr_log = 1'b0;
  endtask

  task automatic clear_log();
    @(negedge clk); clr_log = 1'b1;
    @(negedge clk); clr_log = 1'b0;
  endtask

  task automatic fire(input logic d, input logic s, input logic [7:0] st, input logic o,
                      input logic r, input logic [7:0] rt, input logic ir);
    @(negedge clk);
    insn_end = 1'b1; div_fault = d; swi_req = s; swi_type = st; ovf_req = o;
    intr_req = r; intr_type = rt; iret_end = ir;
    @(negedge clk);
    insn_end = 1'b0; div_fault = 1'b0; swi_req = 1'b0; ovf_req = 1'b0;
    intr_req = 1'b0; iret_end = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic chk_entry(input string tag, input logic [7:0] ty, input logic [15:0] cs0,
                           input logic [15:0] ip0, input logic [15:0] sp0, input logic [15:0] fl0);
    int base;
    base = 32'h20000 + int'(sp0);
    chk("R3 write count", wn, 3);
    chk("R3 flags push addr", lg_a[0], base - 2);
    chk("R3 flags push data", lg_d[0], fl0);
    chk("R3 cs push addr", lg_a[1], base - 4);
    chk("R3 cs push data", lg_d[1], cs0);
    chk("R3 ip push addr", lg_a[2], base - 6);
    chk("R3 ip push data", lg_d[2], ip0);
    chk({tag, " type via IP"}, ip_cur, vecw(int'(ty) * 4));
    chk("R5 CS from type*4+2", cs_cur, vecw(int'(ty) * 4 + 2));
    chk("R3 final SP", sp_cur, sp0 - 16'd6);
    chk("R4 flags cleared", flags_cur, fl0 & ~16'h0300);
  endtask

  typedef struct packed {
    logic       div;
    logic       swi;
    logic [7:0] swt;
    logic       ovf;
    logic       nmi;
    logic       intr;
    logic [7:0] irt;
    logic [15:0] fl;
    logic       take;
    logic [7:0] ety;
  } vec_t;

  // flags: bit 9 enable, bit 8 trap, bit 11 overflow
  localparam vec_t VT [10] = '{
    '{1'b1, 1'b1, 8'h21, 1'b0, 1'b1, 1'b0, 8'h00, 16'h0200, 1'b1, 8'h00}, // R6 divide first
    '{1'b0, 1'b1, 8'h21, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0800, 1'b1, 8'h21}, // R6 INT n over overflow
    '{1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0, 8'h00, 16'h0000, 1'b1, 8'h03}, // R6 breakpoint type 3
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h40, 16'h0A00, 1'b1, 8'h04}, // R7 overflow over NMI
    '{1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 16'h0200, 1'b0, 8'h00}, // R7 no OF, no entry
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'h40, 16'h0300, 1'b1, 8'h02}, // R8 NMI over external
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h88, 16'h0300, 1'b1, 8'h88}, // R9 external over step
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h88, 16'h0100, 1'b1, 8'h01}, // R10 masked, step wins
    '{1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h88, 16'h0000, 1'b0, 8'h00}, // R9 masked, no entry
    '{1'b0, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 8'h00, 16'h08D5, 1'b1, 8'hFF}  // R5 last table entry
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog: got busy hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    vec_t v;
    int   cyc;
    // R1: quiet in and just after reset
    repeat (5) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 mem_valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 strobes after reset", {cs_we, ip_we, sp_we, flags_we}, 0);

    // R2: causes without a boundary do nothing
    set_regs(16'h1234, 16'h5600, 16'h0100, 16'h0300);
    @(negedge clk);
    div_fault = 1'b1; swi_req = 1'b1; swi_type = 8'h21;
    repeat (3) @(negedge clk);
    div_fault = 1'b0; swi_req = 1'b0;
    chk("R2 no boundary busy", busy, 0);
    chk("R2 no boundary writes", wn, 0);

    for (int i = 0; i < 10; i++) begin
      v = VT[i];
      set_regs(16'h1234, 16'h5600 | 16'(i), 16'h0100, v.fl);
      nmi_pin = v.nmi;
      fire(v.div, v.swi, v.swt, v.ovf, v.intr, v.irt, 1'b0);
      if (v.take) chk_entry("R6", v.ety, 16'h1234, 16'h5600 | 16'(i), 16'h0100, v.fl);
      else begin
        repeat (3) @(negedge clk);
        chk("R7/R9 no entry busy", busy, 0);
        chk("R7/R9 no entry writes", wn, 0);
      end
      nmi_pin = 1'b0;
      if (v.nmi && v.ety != 8'h02) begin
        // R8: the losing NMI edge is still pending
        set_regs(16'h1234, 16'h7700, 16'h0100, 16'h0000);
        fire(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
        chk_entry("R8 pending NMI", 8'h02, 16'h1234, 16'h7700, 16'h0100, 16'h0000);
      end
    end

    // R13 and R12: stalled memory, boundary pulsed while busy is ignored
    stall_en = 1'b1;
    set_regs(16'h3333, 16'h4444, 16'h0100, 16'h0200);
    @(negedge clk);
    insn_end = 1'b1; swi_req = 1'b1; swi_type = 8'h10;
    @(negedge clk);
    insn_end = 1'b0; swi_req = 1'b0;
    @(negedge clk);
    insn_end = 1'b1; div_fault = 1'b1;
    @(negedge clk);
    insn_end = 1'b0; div_fault = 1'b0;
    cyc = 3;
    while (busy) begin @(negedge clk); cyc++; end
    chk_entry("R13 stalled entry", 8'h10, 16'h3333, 16'h4444, 16'h0100, 16'h0200);
    repeat (3) @(negedge clk);
    chk("R12 ignored boundary busy", busy, 0);
    chk("R12 ignored boundary writes", wn, 3);
    chk("R13 stalls stretch sequence", 32'(cyc > 8), 1);
    stall_en = 1'b0;

    // R8: a held pin gives one entry
    set_regs(16'h1111, 16'h2222, 16'h0100, 16'h0000);
    nmi_pin = 1'b1;
    fire(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    chk_entry("R8 NMI edge", 8'h02, 16'h1111, 16'h2222, 16'h0100, 16'h0000);
    set_regs(16'h1111, 16'h2222, 16'h0100, 16'h0000);
    fire(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 held pin no second entry", wn, 0);
    nmi_pin = 1'b0;

    // R11: return restores everything, then R10 stepping resumes
    set_regs(16'hABCD, 16'h0042, 16'h0100, 16'h0300);
    fire(1'b0, 1'b1, 8'h30, 1'b0, 1'b0, 8'h00, 1'b0);
    chk_entry("R6 INT n with TF", 8'h30, 16'hABCD, 16'h0042, 16'h0100, 16'h0300);
    fire(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1);
    chk("R11 IP restored", ip_cur, 16'h0042);
    chk("R11 CS restored", cs_cur, 16'hABCD);
    chk("R11 FLAGS restored", flags_cur, 16'h0300);
    chk("R11 SP restored", sp_cur, 16'h0100);
    chk("R11 return writes nothing", wn, 3);
    clear_log();
    fire(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0);
    chk_entry("R10 step after return", 8'h01, 16'hABCD, 16'h0042, 16'h0100, 16'h0300);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule